// File: doc/BRIEF.md
# GPIO bank with per-pin interrupt sensing

A bank of general-purpose pins behind a single-cycle word-addressed register port. Each pin has its own input-enable, output-enable and output-value bits. Pad controls for pull-up and drive strength are stored and brought out unchanged. An alternate-function bit per pin hands the pad to one of two external signals, and a second bit picks which one.

The input path is active only while the pin's input-enable bit is 1. That covers both reading the pin level and every kind of event sensing. The sensed signal is synchronized through two flops and then feeds four sense modes: rising edge, falling edge, high level and low level. Each mode has an enable register and a sticky pending register. A pending bit is cleared by writing 1 to it.

The sense path taps the pad after the output driver. A pin that the bank drives with output enabled can therefore trigger its own interrupts. Each pin has its own registered interrupt line for an external interrupt controller.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset every register reads 0, `pad_oe`, `pad_out` and `irq` are 0, and `bus_rdata` is 0.
- R2: `bus_addr` is a word index. The word indexes are: 1 input enable, 2 output enable, 3 output value, 4 pull-up, 5 drive strength, 6/7 rise enable/pending, 8/9 fall enable/pending, 10/11 high enable/pending, 12/13 low enable/pending, 14 alternate enable, 15 alternate select. Storage registers read back what was written. `bus_rdata` is registered: it shows the word addressed when `bus_re` was sampled, and 0 when `bus_re` was 0. Indexes 16 to 31 read 0, and writes to them have no effect.
- R3: With the alternate-enable bit at 0, `pad_oe` equals the output-enable bit and `pad_out` equals the output-value bit. With it at 1, `pad_oe` is 1 and `pad_out` is `alt_b` if the select bit is 1, otherwise `alt_a`. `pad_pullup` and `pad_drive` equal their registers.
- R4: Word 0 reads the synchronized pin level ANDed with input enable. A pin with input enable at 0 reads 0.
- R5: While a pin's input-enable bit is 0, none of its four pending bits can become set.
- R6: A rising (falling) transition of the sensed level sets the rise (fall) pending bit exactly once. The bit is set at the third clock edge after the pad change is sampled.
- R7: While the sensed level is high (low) with input enable at 1, the high (low) pending bit is set on every cycle. Clearing it while the condition holds does not stick.
- R8: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R9: When an event and a clearing write hit the same pending bit in one cycle, the bit ends up set.
- R10: `irq[i]` is the OR over the four modes of pending AND enable, registered one cycle after the pending and enable registers. A pending bit records events while its enable is 0.
- R11: With a pin's input and output enables both at 1, the sensed level is the driven value. A write of 1 to the output value of a pin armed for rising edges raises its `irq` at the fourth edge after the write's edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word index |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Registered read data |
| pad_in | input | NPINS | Pin levels from the pads |
| pad_out | output | NPINS | Value driven to the pads |
| pad_oe | output | NPINS | Pad driver enable |
| pad_pullup | output | NPINS | Pull-up control |
| pad_drive | output | NPINS | Drive-strength control |
| alt_a | input | NPINS | Alternate function source A |
| alt_b | input | NPINS | Alternate function source B |
| irq | output | NPINS | Per-pin interrupt line |

## Verification
A pad change is sampled at the next edge. It reaches the synchronized level one edge later and sets a pending bit at the third edge. The interrupt line follows at the fourth edge, and a read returns data one edge after its strobe. Most event checks therefore wait five or more cycles before a read, which makes them independent of exact latency. Two checks are instead timed to the cycle. The loopback interrupt must be low after the third edge and high after the fourth. The set-versus-clear case lands a clearing write exactly on the edge where the rise event is registered.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int IDX_W     = 4;
  localparam int MAP_WORDS = 16;
  localparam int NMODES    = 4;

  typedef enum logic [IDX_W-1:0] {
    RG_PIN_LVL  = 4'd0,
    RG_IN_EN    = 4'd1,
    RG_OUT_EN   = 4'd2,
    RG_OUT_VAL  = 4'd3,
    RG_PULL     = 4'd4,
    RG_DRIVE    = 4'd5,
    RG_RISE_EN  = 4'd6,
    RG_RISE_PND = 4'd7,
    RG_FALL_EN  = 4'd8,
    RG_FALL_PND = 4'd9,
    RG_HI_EN    = 4'd10,
    RG_HI_PND   = 4'd11,
    RG_LO_EN    = 4'd12,
    RG_LO_PND   = 4'd13,
    RG_ALT_EN   = 4'd14,
    RG_ALT_SEL  = 4'd15
  } reg_idx_e;

  // mode slots; enable word = 6 + 2*m, pending word = 7 + 2*m
  localparam int MODE_RISE = 0;
  localparam int MODE_FALL = 1;
  localparam int MODE_HI   = 2;
  localparam int MODE_LO   = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] chain [STAGES];
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      prev <= '0;
    end else begin
      chain[0] <= raw;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/gpio_sense.sv
module gpio_sense #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (clr_we ? (pend & ~clr_mask) : pend) | hit;
  end

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((pend & $past(hit)) == $past(hit)));

  // R8
  w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((pend & $past(clr_mask & ~hit)) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pullup,
  output logic [NPINS-1:0]  pad_drive,
  input  logic [NPINS-1:0]  alt_a,
  input  logic [NPINS-1:0]  alt_b,
  output logic [NPINS-1:0]  irq
);
  logic [NPINS-1:0] in_en, out_en, out_val, pull_r, drive_r, alt_en, alt_sel;
  logic [NPINS-1:0] mode_en   [NMODES];
  logic [NPINS-1:0] mode_hit  [NMODES];
  logic [NPINS-1:0] mode_pend [NMODES];
  logic [NPINS-1:0] lvl, rise, fall, sensed_raw, rd_word, irq_next;
  logic [IDX_W-1:0] widx;
  logic             mapped, wr_hit;

  assign widx   = bus_addr[IDX_W-1:0];
  assign mapped = int'(bus_addr) < MAP_WORDS;
  assign wr_hit = bus_we && mapped;

  // storage registers
  always_ff @(posedge clk) begin
    if (rst) begin
      in_en <= '0; out_en <= '0; out_val <= '0; pull_r <= '0;
      drive_r <= '0; alt_en <= '0; alt_sel <= '0;
      for (int m = 0; m < NMODES; m++) mode_en[m] <= '0;
    end else if (wr_hit) begin
      case (reg_idx_e'(widx))
        RG_IN_EN:   in_en   <= bus_wdata;
        RG_OUT_EN:  out_en  <= bus_wdata;
        RG_OUT_VAL: out_val <= bus_wdata;
        RG_PULL:    pull_r  <= bus_wdata;
        RG_DRIVE:   drive_r <= bus_wdata;
        RG_RISE_EN: mode_en[MODE_RISE] <= bus_wdata;
        RG_FALL_EN: mode_en[MODE_FALL] <= bus_wdata;
        RG_HI_EN:   mode_en[MODE_HI]   <= bus_wdata;
        RG_LO_EN:   mode_en[MODE_LO]   <= bus_wdata;
        RG_ALT_EN:  alt_en  <= bus_wdata;
        RG_ALT_SEL: alt_sel <= bus_wdata;
        default: ;
      endcase
    end
  end

  // pad drive path: alternate function bypasses the output registers
  assign pad_oe     = alt_en | out_en;
  assign pad_out    = (alt_en & ((alt_sel & alt_b) | (~alt_sel & alt_a)))
                    | (~alt_en & out_val);
  assign pad_pullup = pull_r;
  assign pad_drive  = drive_r;

  // sense taps the pad after the driver (loopback when driven)
  assign sensed_raw = (pad_oe & pad_out) | (~pad_oe & pad_in);

  gpio_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw(sensed_raw),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  assign mode_hit[MODE_RISE] = in_en & rise;
  assign mode_hit[MODE_FALL] = in_en & fall;
  assign mode_hit[MODE_HI]   = in_en & lvl;
  assign mode_hit[MODE_LO]   = in_en & ~lvl;

  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    logic clr_we_m;
    assign clr_we_m = wr_hit && (widx == IDX_W'(7 + 2*m));
    gpio_sense #(.N(NPINS)) u_pend (
      .clk(clk), .rst(rst), .hit(mode_hit[m]),
      .clr_we(clr_we_m), .clr_mask(bus_wdata), .pend(mode_pend[m])
    );
  end

  // read mux
  always_comb begin
    rd_word = '0;
    if (mapped) begin
      case (reg_idx_e'(widx))
        RG_PIN_LVL:  rd_word = lvl & in_en;
        RG_IN_EN:    rd_word = in_en;
        RG_OUT_EN:   rd_word = out_en;
        RG_OUT_VAL:  rd_word = out_val;
        RG_PULL:     rd_word = pull_r;
        RG_DRIVE:    rd_word = drive_r;
        RG_RISE_EN:  rd_word = mode_en[MODE_RISE];
        RG_RISE_PND: rd_word = mode_pend[MODE_RISE];
        RG_FALL_EN:  rd_word = mode_en[MODE_FALL];
        RG_FALL_PND: rd_word = mode_pend[MODE_FALL];
        RG_HI_EN:    rd_word = mode_en[MODE_HI];
        RG_HI_PND:   rd_word = mode_pend[MODE_HI];
        RG_LO_EN:    rd_word = mode_en[MODE_LO];
        RG_LO_PND:   rd_word = mode_pend[MODE_LO];
        RG_ALT_EN:   rd_word = alt_en;
        RG_ALT_SEL:  rd_word = alt_sel;
        default:     rd_word = '0;
      endcase
    end
  end

  always_comb begin
    irq_next = '0;
    for (int m = 0; m < NMODES; m++) irq_next |= mode_pend[m] & mode_en[m];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= '0;
    end else begin
      bus_rdata <= bus_re ? rd_word : '0;
      irq       <= irq_next;
    end
  end

  // R5
  no_sense_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((((mode_pend[0] & ~$past(mode_pend[0])) |
                (mode_pend[1] & ~$past(mode_pend[1])) |
                (mode_pend[2] & ~$past(mode_pend[2])) |
                (mode_pend[3] & ~$past(mode_pend[3]))) & ~$past(in_en)) == '0));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_en[0] | mode_en[1] | mode_en[2] | mode_en[3]) == '0) |=> (irq == '0));

  // R2
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !mapped) |=> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
  localparam int N  = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0, bus_re = 1'b0;
  logic [N-1:0]  bus_wdata = '0, bus_rdata;
  logic [N-1:0]  pad_in = '0, pad_out, pad_oe, pad_pullup, pad_drive;
  logic [N-1:0]  alt_a = '0, alt_b = '0, irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  logic [N-1:0] shadow [16];

  always #2.5 clk = ~clk;

  gpio_bank #(.NPINS(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup),
    .pad_drive(pad_drive), .alt_a(alt_a), .alt_b(alt_b), .irq(irq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [N-1:0] d);
    bus_addr = AW'(idx); bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [N-1:0] d);
    bus_addr = AW'(idx); bus_re = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int store_idx(input int k);
    case (k)
      0: return 4;  1: return 5;  2: return 6;  3: return 8;
      4: return 10; 5: return 12; 6: return 14; default: return 15;
    endcase
  endfunction

  function automatic logic [N-1:0] exp_out(input logic [N-1:0] ov, aen, asel, a, b);
    return (aen & ((asel & b) | (~asel & a))) | (~aen & ov);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [N-1:0] d;
    void'($urandom(32'h1234abcd));
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);

    // R1 reset state
    chk("R1 irq", irq, '0);
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pad_out", pad_out, '0);
    chk("R1 rdata", bus_rdata, '0);
    for (int i = 0; i < 16; i++) begin
      rd(i, d);
      chk($sformatf("R1 word %0d", i), d, '0);
    end

    // R2 / R3 random storage traffic, input enable stays 0
    for (int it = 0; it < 60; it++) begin
      int wi, ri;
      logic [N-1:0] v;
      wi = store_idx($urandom_range(0, 7));
      v  = $urandom;
      wr(wi, v);
      shadow[wi] = v;
      ri = store_idx($urandom_range(0, 7));
      rd(ri, d);
      chk($sformatf("R2 readback word %0d", ri), d, shadow[ri]);
    end
    alt_a = $urandom; alt_b = $urandom;
    wait_cyc(1);
    chk("R3 pullup", pad_pullup, shadow[4]);
    chk("R3 drive", pad_drive, shadow[5]);
    chk("R3 oe", pad_oe, shadow[14]);
    chk("R3 out", pad_out, exp_out('0, shadow[14], shadow[15], alt_a, alt_b));
    wr(3, 32'hA5A5_0F0F); wr(2, 32'h0000_FFFF); wr(14, 32'h00FF_00FF);
    wait_cyc(1);
    chk("R3 oe mixed", pad_oe, 32'h0000_FFFF | 32'h00FF_00FF);
    chk("R3 out mixed", pad_out, exp_out(32'hA5A5_0F0F, 32'h00FF_00FF, shadow[15], alt_a, alt_b));
    wait_cyc(5);
    rd(7, d); chk("R5 no pending with input off", d, '0);
    chk("R10 irq idle", irq, '0);
    wr(20, 32'hFFFF_FFFF);
    rd(20, d); chk("R2 unmapped read", d, '0);
    rd(4, d); chk("R2 unmapped write no effect", d, shadow[4]);

    // back to a quiet configuration
    for (int i = 1; i < 16; i++) if (i != 7 && i != 9 && i != 11 && i != 13) wr(i, '0);
    alt_a = '0; alt_b = '0;

    // R4 / R6 / R7 / R8 on pin 3 from the pad
    wr(1, 32'h8);
    wait_cyc(5);
    rd(13, d); chk("R7 low level pending", d, 32'h8);
    rd(11, d); chk("R7 high level idle", d, '0);
    pad_in = 32'h8;
    wait_cyc(5);
    rd(7, d);  chk("R6 rise pending", d, 32'h8);
    rd(9, d);  chk("R6 no fall", d, '0);
    rd(11, d); chk("R7 high pending", d, 32'h8);
    rd(0, d);  chk("R4 level read", d, 32'h8);
    wr(7, 32'h8); wait_cyc(3);
    rd(7, d);  chk("R6 edge sets once / R8 clear", d, '0);
    wr(11, 32'h8); wait_cyc(1);
    rd(11, d); chk("R7 level re-sets", d, 32'h8);
    wr(13, 32'h0);
    rd(13, d); chk("R8 write zero keeps", d, 32'h8);
    wr(13, 32'h8); wait_cyc(2);
    rd(13, d); chk("R8 write one clears", d, '0);
    pad_in = 32'h0;
    wait_cyc(5);
    rd(9, d);  chk("R6 fall pending", d, 32'h8);

    // R5 input disabled: toggling does nothing
    wr(1, '0);
    wr(7, '1); wr(9, '1); wr(11, '1); wr(13, '1);
    pad_in = 32'h28; wait_cyc(5);
    pad_in = 32'h0;  wait_cyc(5);
    rd(7, d);  chk("R5 rise", d, '0);
    rd(9, d);  chk("R5 fall", d, '0);
    rd(11, d); chk("R5 high", d, '0);
    rd(13, d); chk("R5 low", d, '0);
    pad_in = 32'h28; wait_cyc(5);
    rd(0, d);  chk("R4 disabled level reads 0", d, '0);
    pad_in = 32'h0;

    // R10 pending records with enable off, irq follows enable
    wr(1, 32'h1);
    wait_cyc(6);
    chk("R10 irq masked", irq, '0);
    rd(13, d); chk("R10 pending while masked", d, 32'h1);
    wr(12, 32'h1); wait_cyc(1);
    chk("R10 irq raised", irq, 32'h1);
    wr(12, 32'h0); wait_cyc(1);
    chk("R10 irq dropped", irq, '0);

    // R11 loopback, exact latency
    wr(2, 32'h1);
    wr(7, '1); wr(9, '1);
    wr(6, 32'h1);
    wait_cyc(4);
    wr(3, 32'h1);
    chk("R3 driven pin", pad_out & pad_oe, 32'h1);
    wait_cyc(3);
    chk("R11 irq not yet at edge 3", irq, '0);
    wait_cyc(1);
    chk("R11 irq at edge 4", irq, 32'h1);

    // R9 event and clear on the same edge
    wr(3, 32'h0);
    wait_cyc(5);
    wr(3, 32'h1);
    wait_cyc(2);
    wr(7, 32'h1);
    rd(7, d); chk("R9 set beats clear", d, 32'h1);
    wr(7, 32'h1);
    rd(7, d); chk("R9 later clear takes", d, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule